// File: doc/BRIEF.md
# Two-Stage SCL Bit-Rate Divider

This block derives the serial-clock timing of an I2C master from the system clock. Two programmable counters are chained: the first divides the system clock by (a+1) and its carry steps the second, which divides again by (b+1). Every carry of the second stage is a tick, and the tick rate is 22 times the SCL rate. A 22-step phase counter advances once per tick. The lower half of its range holds SCL low, the upper half releases SCL high, and one step inside the low half is the only slot where SDA may change. The SCL frequency is therefore the system clock divided by 22·(a+1)·(b+1). It can never be faster than the system clock divided by 22.

The divider settings arrive as one 8-bit word with a load strobe. Each load copies both fields and restarts all three counters from zero, so a new rate always starts from a clean SCL-low phase. Software is expected to load only while the bus is idle. The transfer core can assert a stall input while it is not ready. The phase counter then freezes as long as SCL is in its low half, and the prescale counters keep running. No data stream passes through the block, so every pin is plain control or status with no valid/ready handshake.

Top module: `scl_tick_gen`

## Requirements
- R1: `tick` pulses for one cycle every (a+1)·(b+1) system clocks. After a restart, the first pulse comes in the cycle that ends (a+1)·(b+1)−1 rising edges later. Here a is the value held from `div_word[7:6]` and b is the value held from `div_word[5:0]`.
- R2: `phase` holds a value from 0 to 21. It advances by one on the clock edge that ends each tick cycle and wraps from 21 to 0, so one SCL period lasts 22 ticks.
- R3: `scl_low` is 1 while `phase` is 0 to 10 and 0 while `phase` is 11 to 21.
- R4: `sda_win` is 1 only while `phase` equals 5, which lies inside the SCL-low half.
- R5: While `stall` is 1 and `phase` is 0 to 10, `phase` does not change. While `phase` is 11 to 21, `stall` has no effect. The prescale counters run on in both cases, so tick timing is unchanged by a stall.
- R6: A clock edge with `div_load` at 1 takes both fields from `div_word` and clears the prescale and phase counters. The cycle after that edge counts as cycle 0 of a restart.
- R7: During reset and just after it, `phase` is 0 and both dividers hold 0.
- R8: With a = 0 and b = 0, `tick` is 1 in every cycle, and `phase` steps once per clock. This is the fastest rate, SCL = system clock / 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_load | input | 1 | Load strobe for the divider word; restarts all counters |
| div_word | input | 8 | Divider settings: bits [7:6] hold a, bits [5:0] hold b |
| stall | input | 1 | Transfer core not ready; freezes the phase while SCL is low |
| tick | output | 1 | One-cycle pulse at 22 times the SCL rate |
| phase | output | 5 | Current step of the 22-step SCL phase sequence |
| scl_low | output | 1 | 1 while SCL is driven low |
| sda_win | output | 1 | 1 during the single step where SDA may change |

## Verification
`tick` is decoded directly from the counter registers. In the cycle numbered (a+1)·(b+1)−1 after a restart, counted in rising edges, it is already visible. `phase` moves on the edge that closes that cycle. `scl_low` and `sda_win` follow `phase` within the same cycle, and a load takes effect on the first edge that sees the strobe. The bench drives inputs and samples outputs only on falling clock edges and counts whole cycles from the load edge. Every expected value is therefore taken in the exact cycle these latencies predict, with no margin.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int STEPS     = 22;
  localparam int LOW_STEPS = 11;
  localparam int SDA_STEP  = 5;
  localparam int PHASE_W   = $clog2(STEPS);
  typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/scl_prescale_stage.sv
module scl_prescale_stage #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         carry
);
  logic [W-1:0] cnt_q;

  assign carry = en && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (carry) cnt_q <= '0;
    else if (en)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_div_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   step,
  input  logic   stall,
  output phase_t phase,
  output logic   scl_low,
  output logic   sda_win
);
  localparam phase_t LAST = phase_t'(STEPS - 1);
  localparam phase_t LOWN = phase_t'(LOW_STEPS);
  localparam phase_t SDAP = phase_t'(SDA_STEP);

  phase_t ph_q;
  logic   in_low;
  logic   adv;

  assign in_low  = ph_q < LOWN;
  assign adv     = step && !(stall && in_low);
  assign phase   = ph_q;
  assign scl_low = in_low;
  assign sda_win = (ph_q == SDAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ph_q <= '0;
    else if (clr) ph_q <= '0;
    else if (adv) ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
  end
endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen
  import scl_div_pkg::*;
#(
  parameter int A_W   = 2,
  parameter int B_W   = 6,
  parameter int DEF_A = 0,
  parameter int DEF_B = 0,
  localparam int WORD_W = A_W + B_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_load,
  input  logic [WORD_W-1:0] div_word,
  input  logic              stall,
  output logic              tick,
  output logic [PHASE_W-1:0] phase,
  output logic              scl_low,
  output logic              sda_win
);
  logic [A_W-1:0] div_a_q;
  logic [B_W-1:0] div_b_q;
  logic           carry_a;
  logic           carry_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_a_q <= A_W'(DEF_A);
      div_b_q <= B_W'(DEF_B);
    end else if (div_load) begin
      div_a_q <= div_word[WORD_W-1 -: A_W];
      div_b_q <= div_word[B_W-1:0];
    end
  end

  scl_prescale_stage #(.W(A_W)) u_stage_a (
    .clk(clk), .rst_n(rst_n), .clr(div_load), .en(1'b1),
    .limit(div_a_q), .carry(carry_a)
  );

  scl_prescale_stage #(.W(B_W)) u_stage_b (
    .clk(clk), .rst_n(rst_n), .clr(div_load), .en(carry_a),
    .limit(div_b_q), .carry(carry_b)
  );

  assign tick = carry_b;

  scl_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .clr(div_load), .step(carry_b),
    .stall(stall), .phase(phase), .scl_low(scl_low), .sda_win(sda_win)
  );
endmodule

// File: rtl/scl_tick_gen_chk.sv
module scl_tick_gen_chk
  import scl_div_pkg::*;
#(
  parameter int A_W = 2,
  parameter int B_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               div_load,
  input logic               stall,
  input logic               tick,
  input logic [PHASE_W-1:0] phase,
  input logic               scl_low,
  input logic               sda_win,
  input logic [A_W-1:0]     div_a,
  input logic [B_W-1:0]     div_b
);
  logic [A_W+B_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= '0;
    else if (div_load || tick) gap_q <= '0;
    else                       gap_q <= gap_q + 1'b1;
  end

  // R1
  tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (int'(gap_q) == (int'(div_a) + 1) * (int'(div_b) + 1) - 1));

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase) < STEPS);

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_load && tick && !(stall && scl_low)) |=>
      (int'(phase) == ((int'($past(phase)) == STEPS - 1) ? 0 : int'($past(phase)) + 1)));

  // R4
  sda_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_win |-> scl_low);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_load && stall && scl_low) |=> $stable(phase));

  // R6
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_load |=> (phase == '0));
endmodule

bind scl_tick_gen scl_tick_gen_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_load(div_load), .stall(stall),
  .tick(tick), .phase(phase), .scl_low(scl_low), .sda_win(sda_win),
  .div_a(div_a_q), .div_b(div_b_q)
);

// File: tb/sim_scl_tick_gen.sv
module sim_scl_tick_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_load = 1'b0;
  logic [7:0] div_word = 8'h00;
  logic       stall = 1'b0;
  logic       tick;
  logic [4:0] phase;
  logic       scl_low;
  logic       sda_win;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scl_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .div_load(div_load), .div_word(div_word),
    .stall(stall), .tick(tick), .phase(phase), .scl_low(scl_low), .sda_win(sda_win)
  );

  localparam int NV = 7;
  localparam logic [7:0] V_WORD [NV] = '{8'h00, 8'h42, 8'hFF, 8'h85, 8'h40, 8'h09, 8'hC0};
  localparam int         V_N    [NV] = '{5, 17, 2819, 395, 44, 55, 121};
  localparam int         V_PH   [NV] = '{5, 2, 11, 21, 0, 5, 8};
  localparam logic       V_TK   [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] w);
    @(negedge clk);
    div_word = w;
    div_load = 1'b1;
    @(negedge clk);
    div_load = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_phase(input string req, input int exp);
    chk(int'(phase) == exp, req, int'(phase), exp);
  endtask

  initial begin
    // R7: reset state
    wait_cyc(3);
    chk_phase("R7 phase in reset", 0);
    chk(scl_low == 1'b1, "R7 scl_low in reset", int'(scl_low), 1);
    rst_n = 1'b1;
    wait_cyc(3);
    // R8: default dividers 0/0 step the phase each clock
    chk_phase("R8 default divide", 3);
    chk(tick == 1'b1, "R8 tick every cycle", int'(tick), 1);

    // R1 R2 R3 R4 R6: vector table
    for (int i = 0; i < NV; i++) begin
      load(V_WORD[i]);
      wait_cyc(V_N[i]);
      chk_phase($sformatf("R2 phase vec%0d", i), V_PH[i]);
      chk(tick == V_TK[i], $sformatf("R1 tick vec%0d", i), int'(tick), int'(V_TK[i]));
      chk(scl_low == (V_PH[i] < 11), $sformatf("R3 scl_low vec%0d", i),
          int'(scl_low), int'(V_PH[i] < 11));
      chk(sda_win == (V_PH[i] == 5), $sformatf("R4 sda_win vec%0d", i),
          int'(sda_win), int'(V_PH[i] == 5));
    end

    // R6: reload mid-count restarts from zero (a=3,b=3, period 16)
    load(8'hC3);
    wait_cyc(37);
    chk_phase("R6 before reload", 2);
    load(8'hC3);
    chk_phase("R6 right after reload", 0);
    wait_cyc(15);
    chk(tick == 1'b1, "R6 first tick after reload", int'(tick), 1);
    chk_phase("R6 phase at first tick", 0);
    wait_cyc(1);
    chk_phase("R6 phase after first tick", 1);

    // R5: stall in low half (a=1,b=1, period 4)
    load(8'h41);
    wait_cyc(12);
    chk_phase("R5 before stall", 3);
    stall = 1'b1;
    wait_cyc(40);
    chk_phase("R5 held while stalled", 3);
    stall = 1'b0;
    wait_cyc(4);
    chk_phase("R5 resumes on prescaler timing", 4);

    // R5: stall ignored in high half, then holds once wrapped to 0
    load(8'h00);
    wait_cyc(13);
    chk_phase("R5 high half start", 13);
    stall = 1'b1;
    wait_cyc(3);
    chk_phase("R5 stall ignored while high", 16);
    wait_cyc(6);
    chk_phase("R5 wrapped into low half", 0);
    wait_cyc(5);
    chk_phase("R5 held at step 0", 0);
    chk(scl_low == 1'b1, "R3 scl_low while held", int'(scl_low), 1);
    stall = 1'b0;
    wait_cyc(2);
    chk_phase("R2 resumes after stall", 2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule